// File: doc/BRIEF.md
# Indexed Register Gather Unit

This unit carries out a vector gather between registers of a small local register file. It takes a destination base, an index base, a source base and a vector length VL. For each element position, starting at zero and counting up, it reads an index from the index run. It then copies the source register at that index offset into the matching destination slot. One element completes per clock cycle. An index at or above VL, or any register number that runs past the end of the file, stops the operation with a trap.

Because the register actually read depends on data, the unit reports the whole source range it may touch. This is a bit mask over the register file that a scheduler can use as a dependency window. An optional mode rounds the window length up to a power of two.

A test port loads and inspects the register file while the unit is idle.

Top module: `reg_gather_unit`

## Requirements
- R1: A start pulse sampled while idle raises busy_o on the next cycle. A run without a trap holds busy_o for exactly VL cycles, where VL = vlen_m1_i + 1, and done_o appears together with the fall of busy_o.
- R2: Elements run in ascending order, one per cycle. Element i writes register rd+i with the value of register rs2+v, where v is the value register rs1+i holds at that moment. A write by an earlier element is seen by later elements.
- R3: If v is greater than or equal to VL, element i writes nothing and the run ends. The unit then asserts trap_o and shows i on trap_elem_o together with done_o. Later elements are not written and earlier writes remain.
- R4: The same trap happens when rs1+i, rs2+v or rd+i exceeds 31.
- R5: While busy_o is high, dep_mask_o has bit b set exactly when rs2 <= b < rs2+VL, with bits above 31 dropped. While busy_o is low, dep_mask_o is all zero.
- R6: With pow2_i set at start, the window length in R5 becomes the smallest power of two that is at least VL.
- R7: start_i is ignored while busy_o is high. The operands, the mask and the results of the run in progress are unchanged, and no second run follows.
- R8: With busy_o low, tl_we_i writes tl_wdata_i into register tl_addr_i on the clock edge. tl_rdata_o always shows register tl_addr_i without delay. While busy_o is high, tl_we_i has no effect.
- R9: After reset, busy_o, done_o, trap_o and dep_mask_o are zero and every register reads zero.
- R10: done_o is a single-cycle pulse. trap_o and trap_elem_o keep their value until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Launch a gather (sampled while idle) |
| rd_i | input | 5 | Destination base register |
| rs1_i | input | 5 | Index base register |
| rs2_i | input | 5 | Source base register |
| vlen_m1_i | input | 4 | Vector length minus one |
| pow2_i | input | 1 | Round dependency window up to a power of two |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| trap_o | output | 1 | Last run ended on a fault |
| trap_elem_o | output | 4 | Element number that faulted |
| dep_mask_o | output | 32 | Source dependency window |
| tl_we_i | input | 1 | Test-port write enable |
| tl_addr_i | input | 5 | Test-port register number |
| tl_wdata_i | input | 32 | Test-port write data |
| tl_rdata_o | output | 32 | Test-port read data |

## Verification
A test-port write and an element write can reach the register file in the same cycle. They meet when the bench drives tl_we_i during a run while the sequencer is storing its current element. The bench targets a register outside the destination run. After done_o it reads that register back, and it must hold its pre-run value. A start pulse driven while busy can also coincide with element processing. That case is judged by an unchanged dependency mask, by results that match only the first operation, and by busy_o staying low after done_o.

// File: rtl/gather_pkg.sv
package gather_pkg;
  // smallest power of two not below v, searched up to 2**lim
  function automatic int pow2_ceil(input int v, input int lim);
    int r;
    r = 1 << lim;
    for (int k = lim; k >= 0; k--)
      if ((1 << k) >= v) r = 1 << k;
    return r;
  endfunction
endpackage

// File: rtl/gather_rf.sv
module gather_rf #(
  parameter int NREG = 32,
  parameter int DW   = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] ra_addr_i,
  output logic [DW-1:0] ra_data_o,
  input  logic [AW-1:0] rb_addr_i,
  output logic [DW-1:0] rb_data_o,
  input  logic [AW-1:0] rc_addr_i,
  output logic [DW-1:0] rc_data_o
);
  logic [DW-1:0] mem_q [NREG];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREG; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign ra_data_o = mem_q[ra_addr_i];
  assign rb_data_o = mem_q[rb_addr_i];
  assign rc_data_o = mem_q[rc_addr_i];
endmodule

// File: rtl/gather_dep.sv
module gather_dep #(
  parameter int NREG  = 32,
  parameter int MAXVL = 16,
  localparam int AW   = $clog2(NREG),
  localparam int EW   = $clog2(MAXVL)
) (
  input  logic            en_i,
  input  logic [AW-1:0]   base_i,
  input  logic [EW-1:0]   vlm1_i,
  input  logic            pow2_i,
  output logic [NREG-1:0] mask_o
);
  int len;

  always_comb begin
    len = int'(vlm1_i) + 1;
    if (pow2_i) len = gather_pkg::pow2_ceil(len, EW);
  end

  for (genvar b = 0; b < NREG; b++) begin : g_bit
    assign mask_o[b] = en_i && (b >= int'(base_i)) && (b < int'(base_i) + len);
  end
endmodule

// File: rtl/gather_seq.sv
module gather_seq #(
  parameter int NREG  = 32,
  parameter int DW    = 32,
  parameter int MAXVL = 16,
  localparam int AW   = $clog2(NREG),
  localparam int EW   = $clog2(MAXVL),
  localparam int LW   = EW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] rd_i,
  input  logic [AW-1:0] rs1_i,
  input  logic [AW-1:0] rs2_i,
  input  logic [EW-1:0] vlm1_i,
  input  logic          pow2_i,
  input  logic [DW-1:0] idx_val_i,
  output logic [AW-1:0] idx_addr_o,
  output logic [AW-1:0] src_addr_o,
  output logic          we_o,
  output logic [AW-1:0] waddr_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          trap_o,
  output logic [EW-1:0] trap_elem_o,
  output logic [AW-1:0] rs2_o,
  output logic [EW-1:0] vlm1_o,
  output logic          pow2_o
);
  logic [AW-1:0] rd_q, rs1_q, rs2_q;
  logic [EW-1:0] vlm1_q, elem_q, trap_elem_q;
  logic          pow2_q, busy_q, done_q, trap_q;
  logic [AW:0]   idx_sum, src_sum, dst_sum;
  logic [LW-1:0] vl_w;
  logic          idx_big, fault;

  always_comb begin
    vl_w    = LW'(vlm1_q) + LW'(1);
    idx_sum = {1'b0, rs1_q} + (AW+1)'(elem_q);
    dst_sum = {1'b0, rd_q} + (AW+1)'(elem_q);
    idx_big = idx_val_i >= DW'(vl_w);
    src_sum = {1'b0, rs2_q} + (AW+1)'(idx_val_i[EW-1:0]);
    fault   = busy_q && (idx_sum >= (AW+1)'(NREG) || idx_big ||
                         src_sum >= (AW+1)'(NREG) || dst_sum >= (AW+1)'(NREG));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q <= '0; rs1_q <= '0; rs2_q <= '0; vlm1_q <= '0; pow2_q <= 1'b0;
      elem_q <= '0; trap_elem_q <= '0;
      busy_q <= 1'b0; done_q <= 1'b0; trap_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start_i) begin
          rd_q <= rd_i; rs1_q <= rs1_i; rs2_q <= rs2_i;
          vlm1_q <= vlm1_i; pow2_q <= pow2_i;
          elem_q <= '0; trap_q <= 1'b0; trap_elem_q <= '0;
          busy_q <= 1'b1;
        end
      end else if (fault) begin
        busy_q <= 1'b0; done_q <= 1'b1;
        trap_q <= 1'b1; trap_elem_q <= elem_q;
      end else if (elem_q == vlm1_q) begin
        busy_q <= 1'b0; done_q <= 1'b1;
      end else begin
        elem_q <= elem_q + EW'(1);
      end
    end
  end

  assign idx_addr_o  = idx_sum[AW-1:0];
  assign src_addr_o  = src_sum[AW-1:0];
  assign waddr_o     = dst_sum[AW-1:0];
  assign we_o        = busy_q && !fault;
  assign busy_o      = busy_q;
  assign done_o      = done_q;
  assign trap_o      = trap_q;
  assign trap_elem_o = trap_elem_q;
  assign rs2_o       = rs2_q;
  assign vlm1_o      = vlm1_q;
  assign pow2_o      = pow2_q;

  // R1
  done_after_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> $past(busy_q));
  // R3
  trap_elem_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_q |-> trap_elem_q <= vlm1_q);
endmodule

// File: rtl/reg_gather_unit.sv
module reg_gather_unit #(
  parameter int NREG  = 32,
  parameter int DW    = 32,
  parameter int MAXVL = 16,
  localparam int AW   = $clog2(NREG),
  localparam int EW   = $clog2(MAXVL)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [AW-1:0]   rd_i,
  input  logic [AW-1:0]   rs1_i,
  input  logic [AW-1:0]   rs2_i,
  input  logic [EW-1:0]   vlen_m1_i,
  input  logic            pow2_i,
  output logic            busy_o,
  output logic            done_o,
  output logic            trap_o,
  output logic [EW-1:0]   trap_elem_o,
  output logic [NREG-1:0] dep_mask_o,
  input  logic            tl_we_i,
  input  logic [AW-1:0]   tl_addr_i,
  input  logic [DW-1:0]   tl_wdata_i,
  output logic [DW-1:0]   tl_rdata_o
);
  logic [AW-1:0] idx_addr, src_addr, seq_waddr, rs2_q, rf_waddr;
  logic [DW-1:0] idx_val, src_val, rf_wdata;
  logic [EW-1:0] vlm1_q;
  logic          seq_we, pow2_q, rf_we;

  gather_seq #(.NREG(NREG), .DW(DW), .MAXVL(MAXVL)) u_seq (
    .clk_i, .rst_ni, .start_i,
    .rd_i, .rs1_i, .rs2_i, .vlm1_i(vlen_m1_i), .pow2_i,
    .idx_val_i(idx_val),
    .idx_addr_o(idx_addr), .src_addr_o(src_addr),
    .we_o(seq_we), .waddr_o(seq_waddr),
    .busy_o, .done_o, .trap_o, .trap_elem_o,
    .rs2_o(rs2_q), .vlm1_o(vlm1_q), .pow2_o(pow2_q)
  );

  // sequencer owns the write port while busy; test writes are dropped then
  always_comb begin
    rf_we    = busy_o ? seq_we : tl_we_i;
    rf_waddr = busy_o ? seq_waddr : tl_addr_i;
    rf_wdata = busy_o ? src_val : tl_wdata_i;
  end

  gather_rf #(.NREG(NREG), .DW(DW)) u_rf (
    .clk_i, .rst_ni,
    .we_i(rf_we), .waddr_i(rf_waddr), .wdata_i(rf_wdata),
    .ra_addr_i(idx_addr), .ra_data_o(idx_val),
    .rb_addr_i(src_addr), .rb_data_o(src_val),
    .rc_addr_i(tl_addr_i), .rc_data_o(tl_rdata_o)
  );

  gather_dep #(.NREG(NREG), .MAXVL(MAXVL)) u_dep (
    .en_i(busy_o), .base_i(rs2_q), .vlm1_i(vlm1_q), .pow2_i(pow2_q),
    .mask_o(dep_mask_o)
  );

  // R10
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R5
  mask_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> dep_mask_o != '0);
  // R7
  mask_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(dep_mask_o));
endmodule

// File: tb/sim_reg_gather_unit.sv
`timescale 1ns/1ps
module sim_reg_gather_unit;
  typedef struct packed {
    logic [4:0] rd;
    logic [4:0] rs1;
    logic [4:0] rs2;
    logic [3:0] vlm1;
    logic       pow2;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{5'd20, 5'd0,  5'd4,  4'd7,  1'b0},
    '{5'd10, 5'd2,  5'd12, 4'd9,  1'b1},
    '{5'd4,  5'd0,  5'd2,  4'd15, 1'b0},
    '{5'd28, 5'd0,  5'd0,  4'd5,  1'b1},
    '{5'd0,  5'd24, 5'd29, 4'd3,  1'b0},
    '{5'd8,  5'd30, 5'd16, 4'd4,  1'b1}
  };

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic start_i = 1'b0, pow2_i = 1'b0, tl_we_i = 1'b0;
  logic [4:0] rd_i = '0, rs1_i = '0, rs2_i = '0, tl_addr_i = '0;
  logic [3:0] vlen_m1_i = '0;
  logic [31:0] tl_wdata_i = '0;
  logic busy_o, done_o, trap_o;
  logic [3:0] trap_elem_o;
  logic [31:0] dep_mask_o, tl_rdata_o;

  int checks = 0, errors = 0, cyc = 0;
  bit finished = 1'b0;
  logic [31:0] model [32];
  bit exp_trap;
  int exp_elem;

  always #2 clk_i = ~clk_i;

  reg_gather_unit u0 (.*);

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 100000) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
      finish_run();
    end
  end

  function automatic logic [31:0] fill(input int r, input int k);
    if (k % 2 == 0) return 32'((r * 3 + k) % 4);
    return 32'((r * 3 + k) % 23);
  endfunction

  function automatic logic [31:0] exp_mask(input vec_t v);
    int w;
    logic [31:0] m;
    w = int'(v.vlm1) + 1;
    if (v.pow2) begin
      int p;
      p = 1;
      while (p < w) p = p * 2;
      w = p;
    end
    m = '0;
    for (int b = 0; b < 32; b++)
      if (b >= int'(v.rs2) && b < int'(v.rs2) + w) m[b] = 1'b1;
    return m;
  endfunction

  // sequential reference of the gather loop
  task automatic model_op(input vec_t v);
    int vl;
    vl = int'(v.vlm1) + 1;
    exp_trap = 1'b0; exp_elem = 0;
    for (int e = 0; e < vl; e++) begin
      int a, s, d;
      logic [31:0] iv;
      a = int'(v.rs1) + e;
      d = int'(v.rd) + e;
      if (a > 31) begin exp_trap = 1'b1; exp_elem = e; break; end
      iv = model[a];
      if (iv >= 32'(vl)) begin exp_trap = 1'b1; exp_elem = e; break; end
      s = int'(v.rs2) + int'(iv);
      if (s > 31 || d > 31) begin exp_trap = 1'b1; exp_elem = e; break; end
      model[d] = model[s];
    end
  endtask

  task automatic tl_write(input int a, input logic [31:0] d);
    @(negedge clk_i);
    tl_we_i = 1'b1; tl_addr_i = 5'(a); tl_wdata_i = d;
    @(negedge clk_i);
    tl_we_i = 1'b0;
  endtask

  task automatic load_all(input int k);
    for (int r = 0; r < 32; r++) begin
      tl_write(r, fill(r, k));
      model[r] = fill(r, k);
    end
  endtask

  task automatic read_reg(input int a, output logic [31:0] d);
    @(negedge clk_i);
    tl_addr_i = 5'(a);
    #1 d = tl_rdata_o;
  endtask

  task automatic check_regs(input string req);
    logic [31:0] d;
    for (int r = 0; r < 32; r++) begin
      read_reg(r, d);
      chk(req, $sformatf("reg%0d", r), d, model[r]);
    end
  endtask

  // launch, optionally poke start and the test port during the run
  task automatic run_op(input vec_t v, input bit poke);
    int cnt;
    logic [31:0] m0;
    @(negedge clk_i);
    rd_i = v.rd; rs1_i = v.rs1; rs2_i = v.rs2;
    vlen_m1_i = v.vlm1; pow2_i = v.pow2; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    chk("R1", "busy after start", 32'(busy_o), 32'd1);
    chk("R5/R6", "dep mask", dep_mask_o, exp_mask(v));
    m0 = dep_mask_o;
    if (poke) begin
      start_i = 1'b1; rd_i = 5'd1; rs1_i = 5'd2; rs2_i = 5'd0;
      vlen_m1_i = 4'd0; pow2_i = 1'b0;
      tl_we_i = 1'b1; tl_addr_i = 5'd31; tl_wdata_i = 32'hdead_beef;
    end
    cnt = 0;
    do begin
      @(negedge clk_i);
      start_i = 1'b0; tl_we_i = 1'b0;
      cnt++;
      if (poke && cnt == 1 && busy_o)
        chk("R7", "mask kept under start", dep_mask_o, m0);
    end while (!done_o && cnt < 64);
    chk("R1/R3", "cycles to done", 32'(cnt), 32'(exp_trap ? exp_elem + 1 : int'(v.vlm1) + 1));
    chk("R3/R4", "trap flag", 32'(trap_o), 32'(exp_trap));
    if (exp_trap) chk("R3/R4", "trap elem", 32'(trap_elem_o), 32'(exp_elem));
    chk("R5", "mask idle at done", dep_mask_o, '0);
    @(negedge clk_i);
    chk("R10", "done pulse", 32'(done_o), 32'd0);
    chk("R10", "trap held", 32'(trap_o), 32'(exp_trap));
    if (poke) chk("R7", "no second run", 32'(busy_o), 32'd0);
  endtask

  initial begin
    logic [31:0] d;
    #9 rst_ni = 1'b1;
    @(negedge clk_i);
    // R9
    chk("R9", "busy reset", 32'(busy_o), 32'd0);
    chk("R9", "done reset", 32'(done_o), 32'd0);
    chk("R9", "trap reset", 32'(trap_o), 32'd0);
    chk("R9", "mask reset", dep_mask_o, '0);
    read_reg(5, d);
    chk("R9", "reg reset", d, '0);

    // R2 R3 R4 R5 R6 table walk
    for (int k = 0; k < NV; k++) begin
      load_all(k);
      model_op(VECS[k]);
      run_op(VECS[k], 1'b0);
      check_regs("R2/R3/R4");
    end

    // R8 test port immediate read back
    tl_write(7, 32'h1234_5678);
    read_reg(7, d);
    chk("R8", "test write idle", d, 32'h1234_5678);

    // R7 R8 start and test write during a run
    load_all(0);
    model_op(VECS[0]);
    run_op(VECS[0], 1'b1);
    check_regs("R7/R8");

    // R3 index exactly VL traps on element 0
    load_all(0);
    tl_write(0, 32'd4); model[0] = 32'd4;
    model_op('{5'd20, 5'd0, 5'd4, 4'd3, 1'b0});
    run_op('{5'd20, 5'd0, 5'd4, 4'd3, 1'b0}, 1'b0);
    chk("R3", "trap at index==VL", 32'(trap_o), 32'd1);
    check_regs("R3");

    // R1 single element run
    load_all(2);
    model_op('{5'd31, 5'd0, 5'd6, 4'd0, 1'b1});
    run_op('{5'd31, 5'd0, 5'd6, 4'd0, 1'b1}, 1'b0);
    check_regs("R1");

    finish_run();
  end
endmodule